// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block is the host side of a link to an 8-channel, 12-bit serial converter that runs its conversions on its own internal clock. A single-cycle request carries a channel number, a range bit, a polarity bit, a two-bit power mode and a frame-length choice. The controller packs these into an 8-bit command, pulls chip select low and shifts the command out MSB first. It then parks the serial clock low while the converter works.

The converter reports completion with a strobe that it drops after the eighth command clock and raises again when the result is ready. The controller resumes on the synchronised rising edge of that strobe. If no rising edge arrives, it resumes after a fixed wait derived from the system clock frequency. It then clocks in the 12 result bits MSB first, releases chip select and issues a one-cycle valid pulse with the data. An error flag marks results that were taken after the wait ran out. A busy output holds off new work until chip select has been high for a minimum gap.

Top module: `convLinkCtrl`

## Requirements
- R1: While reset is held and in the first cycle after it, csN is 1, sclk is 0, busy is 0, resValid is 0 and resData is 0.
- R2: The command is sent MSB first on din, stable at every sclk rising edge, laid out as bit 7 = 1 (start), bits 6:4 = channel, bit 3 = range, bit 2 = bipolar, bits 1:0 = power mode.
- R3: From the 8th falling sclk edge, sclk stays low with csN low until the strobe has risen or the wait has expired; no sclk edge occurs before the converter's data is ready.
- R4: When the strobe rises during the conversion wait, the controller reads dout on each sclk rising edge; resData carries the first 12 bits received, MSB first, with resTimeout = 0.
- R5: When the strobe does not rise, the controller resumes after TIMEOUT_CYCLES system clocks (SYS_CLK_MHZ × CONV_WAIT_NS / 1000), reads the result the same way and reports resTimeout = 1.
- R6: With reqLongFrame = 0 a frame has 20 sclk rising edges (8 command + 12 result). With reqLongFrame = 1 it has 24 (8 + 16), and the last 4 bits received are discarded.
- R7: csN stays low for the whole frame. sclk is low whenever csN is high. resValid is a one-cycle pulse that rises in the same cycle as csN.
- R8: busy rises in the cycle after a request is accepted and falls only after the chip-select gap. A request while busy is high, including one in the resValid cycle, starts no frame.
- R9: csN stays high for at least CS_GAP system clocks between two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken only while busy is low |
| reqChan | input | 3 | Channel to convert |
| reqRange | input | 1 | Range selection bit |
| reqBipolar | input | 1 | Polarity selection bit |
| reqPower | input | 2 | Power mode bits |
| reqLongFrame | input | 1 | 0: 20-clock frame, 1: 24-clock frame |
| busy | output | 1 | A transaction or the chip-select gap is in progress |
| resValid | output | 1 | One-cycle result pulse |
| resData | output | 12 | Conversion result |
| resTimeout | output | 1 | Result was read after the wait expired |
| csN | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock, idle low |
| din | output | 1 | Command data to the converter |
| dout | input | 1 | Result data from the converter |
| strobe | input | 1 | End-of-conversion strobe from the converter |

## Verification
A new request can land in the very cycle that the result pulse is issued, so acceptance and completion compete for the same cycle. The bench provokes this by raising reqValid in the resValid cycle of chosen sweep transactions. It then judges the outcome at the ports: csN must stay high through the following gap window, and the next real request must still produce a correct frame. The converter model also varies its conversion time per transaction, which moves the strobe edge against the divided clock phase.

// File: rtl/convLinkPkg.sv
package convLinkPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_CONV,
    ST_READ,
    ST_GAP
  } linkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic shiftCmd;
    logic sampleIn;
    logic done;
    logic timedOut;
  } linkCtl_t;

  function automatic logic [7:0] packCommand(input logic [2:0] chan, input logic range,
                                             input logic bipolar, input logic [1:0] power);
    return {1'b1, chan, range, bipolar, power};
  endfunction

endpackage

// File: rtl/convLinkDatapath.sv
module convLinkDatapath
  import convLinkPkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  linkCtl_t         ctl,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             strobe,
  input  logic             dout,
  output logic             strbRise,
  output logic             din,
  output logic             resValid,
  output logic [RES_W-1:0] resData,
  output logic             resTimeout
);

  logic [CMD_W-1:0]     cmdShift;
  logic [RES_W-1:0]     rxShift;
  logic [SYNC_STAGES:0] strbSync;

  assign din      = cmdShift[CMD_W-1];
  assign strbRise = strbSync[SYNC_STAGES-1] & ~strbSync[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdShift   <= '0;
      rxShift    <= '0;
      strbSync   <= '1;
      resValid   <= 1'b0;
      resData    <= '0;
      resTimeout <= 1'b0;
    end else begin
      strbSync <= {strbSync[SYNC_STAGES-1:0], strobe};
      if (ctl.loadCmd) begin
        cmdShift <= cmdByte;
        rxShift  <= '0;
      end else if (ctl.shiftCmd) begin
        cmdShift <= {cmdShift[CMD_W-2:0], 1'b0};
      end
      if (ctl.sampleIn) rxShift <= {rxShift[RES_W-2:0], dout};
      resValid <= ctl.done;
      if (ctl.done) begin
        resData    <= rxShift;
        resTimeout <= ctl.timedOut;
      end
    end
  end

endmodule

// File: rtl/convLinkControl.sv
module convLinkControl
  import convLinkPkg::*;
#(
  parameter int CMD_W          = 8,
  parameter int RES_W          = 12,
  parameter int LONG_LEN       = 16,
  parameter int HALF_DIV       = 2,
  parameter int TIMEOUT_CYCLES = 750,
  parameter int CS_GAP         = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqLongFrame,
  input  logic       strbRise,
  output linkCtl_t   ctl,
  output linkState_t stateOut,
  output logic       busy,
  output logic       csN,
  output logic       sclk
);

  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int CNT_W = $clog2(LONG_LEN + CMD_W + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam int GAP_W = $clog2(CS_GAP + 1);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(RES_W - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);
  localparam logic [CNT_W-1:0] RES_CNT    = CNT_W'(RES_W);

  linkState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [TO_W-1:0]  toCnt;
  logic [GAP_W-1:0] gapCnt;
  logic             longR, timedOutR, halfTick;
  logic [CNT_W-1:0] readLast;

  assign stateOut = state;
  assign readLast = longR ? LONG_LAST : SHORT_LAST;
  assign halfTick = (state == ST_CMD || state == ST_READ) && (divCnt == DIV_W'(HALF_DIV - 1));

  always_comb begin
    ctl.loadCmd  = (state == ST_IDLE) && reqValid;
    ctl.shiftCmd = (state == ST_CMD) && halfTick && sclk;
    ctl.sampleIn = (state == ST_READ) && halfTick && !sclk && (bitCnt < RES_CNT);
    ctl.done     = (state == ST_READ) && halfTick && sclk && (bitCnt == readLast);
    ctl.timedOut = timedOutR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      bitCnt    <= '0;
      toCnt     <= '0;
      gapCnt    <= '0;
      longR     <= 1'b0;
      timedOutR <= 1'b0;
      busy      <= 1'b0;
      csN       <= 1'b1;
      sclk      <= 1'b0;
    end else begin
      if (state == ST_CMD || state == ST_READ)
        divCnt <= halfTick ? '0 : divCnt + 1'b1;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state  <= ST_CMD;
          csN    <= 1'b0;
          busy   <= 1'b1;
          divCnt <= '0;
          bitCnt <= '0;
          sclk   <= 1'b0;
          longR  <= reqLongFrame;
        end
        ST_CMD: if (halfTick) begin
          sclk <= ~sclk;
          if (sclk) begin
            if (bitCnt == CMD_LAST) begin
              state  <= ST_CONV;
              bitCnt <= '0;
              toCnt  <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_CONV: begin
          toCnt <= toCnt + 1'b1;
          if (strbRise || toCnt == TO_W'(TIMEOUT_CYCLES - 1)) begin
            state     <= ST_READ;
            divCnt    <= '0;
            timedOutR <= !strbRise;
          end
        end
        ST_READ: if (halfTick) begin
          sclk <= ~sclk;
          if (sclk) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == readLast) begin
              state  <= ST_GAP;
              csN    <= 1'b1;
              gapCnt <= '0;
            end
          end
        end
        ST_GAP: begin
          gapCnt <= gapCnt + 1'b1;
          if (gapCnt == GAP_W'(CS_GAP - 1)) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/convLinkCtrl.sv
module convLinkCtrl
  import convLinkPkg::*;
#(
  parameter int SYS_CLK_MHZ  = 50,
  parameter int CONV_WAIT_NS = 15000,
  parameter int HALF_DIV     = 2,
  parameter int CS_GAP       = 4,
  parameter int LONG_LEN     = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqChan,
  input  logic        reqRange,
  input  logic        reqBipolar,
  input  logic [1:0]  reqPower,
  input  logic        reqLongFrame,
  output logic        busy,
  output logic        resValid,
  output logic [11:0] resData,
  output logic        resTimeout,
  output logic        csN,
  output logic        sclk,
  output logic        din,
  input  logic        dout,
  input  logic        strobe
);

  localparam int CMD_W          = 8;
  localparam int RES_W          = 12;
  localparam int TIMEOUT_CYCLES = (SYS_CLK_MHZ * CONV_WAIT_NS) / 1000;

  linkCtl_t   ctl;
  linkState_t ctrlState;
  logic       strbRise;

  convLinkControl #(
    .CMD_W(CMD_W), .RES_W(RES_W), .LONG_LEN(LONG_LEN), .HALF_DIV(HALF_DIV),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CS_GAP(CS_GAP)
  ) u_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLongFrame(reqLongFrame),
    .strbRise(strbRise), .ctl(ctl), .stateOut(ctrlState), .busy(busy),
    .csN(csN), .sclk(sclk)
  );

  convLinkDatapath #(
    .CMD_W(CMD_W), .RES_W(RES_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cmdByte(packCommand(reqChan, reqRange, reqBipolar, reqPower)),
    .strobe(strobe), .dout(dout), .strbRise(strbRise), .din(din),
    .resValid(resValid), .resData(resData), .resTimeout(resTimeout)
  );

endmodule

// File: rtl/convLinkChecker.sv
module convLinkChecker
  import convLinkPkg::*;
#(
  parameter int CS_GAP = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sclk,
  input logic       busy,
  input logic       resValid,
  input linkState_t state
);

  localparam int GAP_W = $clog2(CS_GAP + 2);
  logic [GAP_W-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highCnt <= GAP_W'(CS_GAP);
    else if (!csN) highCnt <= '0;
    else if (highCnt < GAP_W'(CS_GAP)) highCnt <= highCnt + 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> (csN && !busy && !resValid)); // R1
  AST_CONV_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV) |-> (!sclk && !csN)); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R7
  AST_VALID_WITH_CS: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (csN && $past(!csN))); // R7
  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R7
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !$past(busy)); // R8
  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (highCnt >= GAP_W'(CS_GAP))); // R9

endmodule

bind convLinkCtrl convLinkChecker #(.CS_GAP(CS_GAP)) u_checker (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .busy(busy),
  .resValid(resValid), .state(ctrlState)
);

// File: tb/convLinkCtrl_bench.sv
`timescale 1ns/1ps
module convLinkCtrl_bench;

  localparam int HALF_DIV = 2;
  localparam int CS_GAP   = 4;
  localparam int TIMEOUT  = (50 * 15000) / 1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqChan = '0;
  logic        reqRange = 1'b0, reqBipolar = 1'b0, reqLongFrame = 1'b0;
  logic [1:0]  reqPower = '0;
  logic        busy, resValid, resTimeout, csN, sclk, din;
  logic [11:0] resData;
  wire         dout;
  logic        strobe;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  convLinkCtrl #(.SYS_CLK_MHZ(50), .CONV_WAIT_NS(15000), .HALF_DIV(HALF_DIV),
                 .CS_GAP(CS_GAP), .LONG_LEN(16), .SYNC_STAGES(2)) u_convLinkCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan), .reqRange(reqRange),
    .reqBipolar(reqBipolar), .reqPower(reqPower), .reqLongFrame(reqLongFrame),
    .busy(busy), .resValid(resValid), .resData(resData), .resTimeout(resTimeout),
    .csN(csN), .sclk(sclk), .din(din), .dout(dout), .strobe(strobe)
  );

  // behavioural converter model
  int         mPhase = 0, mRise = 0, mTmr = 0, mSeq = 0, mViol = 0, mConvLen = 0, mStartErr = 0;
  int         mConvCycles = 100;
  logic       mStuck = 1'b0, mReady = 1'b0, mPrev = 1'b0;
  logic [7:0] mCmd = '0;
  logic [15:0] mOut = '0;
  logic       mStrobe = 1'b1;

  assign strobe = mStrobe;
  assign dout   = csN ? 1'bz : mOut[15];

  always @(negedge clk) begin
    mPrev <= sclk;
    if (!rstN || csN) begin
      mPhase <= 0;
      mRise  <= 0;
      if (!rstN) begin mStrobe <= 1'b1; mOut <= '0; end
    end else begin
      case (mPhase)
        0: if (sclk && !mPrev) begin
             mCmd <= {mCmd[6:0], din};
             mRise <= mRise + 1;
           end else if (!sclk && mPrev && mRise == 8) begin
             mPhase <= 1; mTmr <= 0; mConvLen <= 0; mReady <= 1'b0;
             if (!mStuck) mStrobe <= 1'b0;
             if (!mCmd[7]) mStartErr <= mStartErr + 1;
           end
        1: if (sclk && !mPrev) begin
             mPhase <= 2;
             if (!mReady) mViol <= mViol + 1;
           end else begin
             mConvLen <= mConvLen + 1;
             mTmr <= mTmr + 1;
             if (mTmr == mConvCycles) begin
               mOut <= {mSeq[4:0], mCmd[6:0], 4'b0000};
               mStrobe <= 1'b1;
               mReady <= 1'b1;
               mSeq <= mSeq + 1;
             end
           end
        default: if (!sclk && mPrev) mOut <= {mOut[14:0], 1'b0};
      endcase
    end
  end

  // port monitor: sclk rises per frame, chip-select high time
  int   frameRises = 0, csHigh = 0, lastGap = 0;
  logic monPrevS = 1'b0, monPrevCs = 1'b1;
  always @(negedge clk) begin
    monPrevS  <= sclk;
    monPrevCs <= csN;
    if (!csN && monPrevCs) begin
      frameRises <= 0;
      lastGap <= csHigh;
      csHigh <= 0;
    end else begin
      if (sclk && !monPrevS) frameRises <= frameRises + 1;
      if (csN) csHigh <= csHigh + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int expSeq = 0;

  task automatic runXfer(input logic [2:0] ch, input logic rng, input logic bip,
                         input logic [1:0] pd, input logic lng, input logic stuck,
                         input int conv, input bit probe, input bit gapCheck);
    int n = 0;
    logic [11:0] expData;
    while (busy) @(negedge clk);
    mStuck = stuck;
    mConvCycles = conv;
    reqChan = ch; reqRange = rng; reqBipolar = bip; reqPower = pd; reqLongFrame = lng;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy && !csN, "R8 busy after accept", {busy, csN}, 2'b10);
    while (!resValid && n < 6000) begin @(negedge clk); n++; end
    chk(resValid, "R7 result pulse seen", resValid, 1);
    if (probe) begin
      // request in the resValid cycle must be ignored
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      chk(!resValid, "R7 valid one cycle", resValid, 0);
      begin
        int lowSeen = 0;
        for (int k = 0; k < CS_GAP + 6; k++) begin
          if (!csN) lowSeen++;
          @(negedge clk);
        end
        chk(lowSeen == 0, "R8 request in valid cycle ignored", lowSeen, 0);
      end
    end
    expData = {expSeq[4:0], ch, rng, bip, pd};
    chk(resData == expData, stuck ? "R5 data after wait" : "R4 data on strobe", resData, expData);
    chk(resTimeout == stuck, stuck ? "R5 timeout flag" : "R4 no timeout flag", resTimeout, stuck);
    chk(frameRises == (lng ? 24 : 20), "R6 sclk count", frameRises, lng ? 24 : 20);
    chk(mViol == 0, "R3 no sclk before data ready", mViol, 0);
    chk(mStartErr == 0, "R2 start bit", mStartErr, 0);
    if (stuck) chk(mConvLen >= TIMEOUT, "R5 waited full interval", mConvLen, TIMEOUT);
    else chk(mConvLen >= conv, "R3 held through conversion", mConvLen, conv);
    if (gapCheck) chk(lastGap >= CS_GAP, "R9 cs gap", lastGap, CS_GAP);
    expSeq++;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(csN && !sclk && !busy && !resValid && resData == 0, "R1 reset state",
        {csN, sclk, busy, resValid}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN && !sclk && !busy && !resValid, "R1 after reset", {csN, sclk, busy, resValid}, 4'b1000);
    for (int lng = 0; lng < 2; lng++)
      for (int ch = 0; ch < 8; ch++)
        for (int rb = 0; rb < 4; rb++)
          runXfer(3'(ch), rb[1], rb[0], 2'(ch) ^ 2'(rb), 1'(lng), 1'b0,
                  60 + ch * 17 + rb * 5, (ch == 3 && rb == 1) || (ch == 6 && rb == 2),
                  !(lng == 0 && ch == 0 && rb == 0));
    runXfer(3'd5, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 200, 1'b0, 1'b1);
    runXfer(3'd2, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 200, 1'b0, 1'b1);
    runXfer(3'd7, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 90, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule